// File: doc/BRIEF.md
# Paged Flash Range Erase Sequencer

This block erases a byte range of a paged serial flash through a byte-wide SPI shifter that sits below it. The host gives a start offset and a length in bytes and pulses a start strobe. The sequencer first rejects any request whose offset or length is not a whole number of pages. It then works through the range one page per pass. On each pass it selects chip, sends a four-byte erase command and deselects. It then polls the device status until the device reports ready. It finishes with a one-cycle done or error pulse.

The device address is the page number shifted left by a configurable amount, not a linear byte address. The page size, the shift and the number of pages in an erase block are parameters. On each pass the sequencer sends a block erase if the page starts a block and at least a full block of pages is left. Otherwise it sends a single-page erase. Whichever erase it sends, the range still advances by one page per pass. A host-supplied cycle limit bounds how long the sequencer polls on each pass.

The shifter handshake works byte by byte. The sequencer raises `sf_go_o` for one cycle with the byte on `sf_tx_o`. The shifter returns a one-cycle `sf_ack_i` with the received byte on `sf_rx_i`. Only one byte is outstanding at a time, and `sf_cs_o` frames each transaction.

Top module: `page_erase_seq`

## Requirements
- R1: If the offset or the length is not a multiple of PAGE_BYTES (default 264), the request ends with `err_o` high for one cycle, two clock edges after the start edge, with `err_tmo_o` low and no SPI byte sent.
- R2: A zero length ends with `done_o`, two clock edges after the start edge, and no SPI byte is sent.
- R3: `busy_o` is high from the edge that accepts a start strobe until the result pulse. The pulse lasts one cycle and `busy_o` is low during it. A start strobe that arrives while busy is ignored.
- R4: Each erase command is one chip-select frame of four bytes in this order: opcode, A[23:16], A[15:8], 0x00. A is the page number (offset / PAGE_BYTES) shifted left by PAGE_SHIFT (default 9).
- R5: The opcode is 0x50 (block erase) when the page number's low three bits are zero and at least 8 pages remain. Otherwise it is 0x81 (page erase).
- R6: Each pass covers one page: a request for N pages issues exactly N erase commands, for ascending page numbers starting at offset / PAGE_BYTES.
- R7: After each erase command the chip select is released. The device is then polled with separate two-byte frames, 0xD7 followed by a dummy 0x00. The second received byte has bit 7 set when the device is ready and clear when it is busy. A busy reply leads to another poll frame.
- R8: If a busy reply arrives once at least `tmo_limit_i` cycles have passed since the command's last byte was acknowledged, the request ends with `err_o` and `err_tmo_o` high, and no further command is sent.
- R9: When the last page reports ready, the request ends with a `done_o` pulse and `err_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when idle |
| ofs_i | input | ADDR_W | Start byte offset |
| len_i | input | ADDR_W | Byte count to erase |
| tmo_limit_i | input | TMO_W | Polling limit per pass, in clock cycles |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle pulse: range erased |
| err_o | output | 1 | One-cycle pulse: request failed |
| err_tmo_o | output | 1 | With `err_o`: failure was a poll timeout |
| sf_cs_o | output | 1 | Chip select to the shifter, high = selected |
| sf_go_o | output | 1 | One-cycle request to shift `sf_tx_o` |
| sf_tx_o | output | 8 | Byte to send |
| sf_ack_i | input | 1 | One-cycle pulse: byte shifted |
| sf_rx_i | input | 8 | Byte received with `sf_ack_i` |

## Verification
A request that sends no SPI bytes, either misaligned or of zero length, produces its pulse exactly two edges after the start edge. The bench samples it at the second falling edge and checks that the line is low again at the third. For requests that do use the flash, the result depends on the shifter model's two-cycle acknowledge latency and its busy replies. The bench therefore waits for the pulse with a bound and checks it for one cycle. The command frames, their bytes and the number of poll frames are compared against values the bench computes from the page number, the remaining count and the model's busy count.

// File: rtl/page_erase_seq.sv
module page_erase_seq #(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 264,
  parameter int PAGE_SHIFT = 9,
  parameter int BLK_PAGES  = 8,
  parameter int TMO_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] ofs_i,
  input  logic [ADDR_W-1:0] len_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              err_tmo_o,
  output logic              sf_cs_o,
  output logic              sf_go_o,
  output logic [7:0]        sf_tx_o,
  input  logic              sf_ack_i,
  input  logic [7:0]        sf_rx_i
);
  localparam int BLK_LG = $clog2(BLK_PAGES);
  localparam logic [ADDR_W-1:0] PB  = ADDR_W'(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] BLK = ADDR_W'(BLK_PAGES);
  localparam logic [7:0] OP_BLK = 8'h50, OP_PG = 8'h81, OP_STAT = 8'hD7;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_CGO, S_CWT, S_GAP, S_PGO, S_PWT, S_RGO, S_RWT, S_NEXT, S_FIN
  } st_t;

  st_t st;
  logic [ADDR_W-1:0] page, pages;
  logic [1:0]        idx;
  logic              bad, tmo;
  logic [TMO_W-1:0]  tcnt;
  logic [23:0]       dev_addr;
  logic              use_blk, polling, misal;

  assign dev_addr = 24'(page << PAGE_SHIFT);
  assign use_blk  = (page[BLK_LG-1:0] == '0) && (pages >= BLK);
  assign polling  = (st == S_GAP) || (st == S_PGO) || (st == S_PWT) ||
                    (st == S_RGO) || (st == S_RWT);
  assign misal    = ((ofs_i % PB) != '0) || ((len_i % PB) != '0);

  assign busy_o    = (st != S_IDLE) && (st != S_FIN);
  assign done_o    = (st == S_FIN) && !bad;
  assign err_o     = (st == S_FIN) && bad;
  assign err_tmo_o = err_o && tmo;
  assign sf_go_o   = (st == S_CGO) || (st == S_PGO) || (st == S_RGO);
  assign sf_cs_o   = (st == S_CGO) || (st == S_CWT) || (st == S_PGO) ||
                     (st == S_PWT) || (st == S_RGO) || (st == S_RWT);

  always_comb begin
    sf_tx_o = 8'h00;
    if (st == S_CGO) begin
      case (idx)
        2'd0:    sf_tx_o = use_blk ? OP_BLK : OP_PG;
        2'd1:    sf_tx_o = dev_addr[23:16];
        2'd2:    sf_tx_o = dev_addr[15:8];
        default: sf_tx_o = 8'h00;
      endcase
    end else if (st == S_PGO) begin
      sf_tx_o = OP_STAT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               tcnt <= '0;
    else if (st == S_CWT)     tcnt <= '0;
    else if (polling && tcnt != '1) tcnt <= tcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      page  <= '0;
      pages <= '0;
      idx   <= '0;
      bad   <= 1'b0;
      tmo   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          page  <= ofs_i / PB;
          pages <= len_i / PB;
          bad   <= misal;
          tmo   <= 1'b0;
          st    <= S_CHK;
        end
        S_CHK: begin
          idx <= '0;
          if (bad || pages == '0) st <= S_FIN;
          else                    st <= S_CGO;
        end
        S_CGO: st <= S_CWT;
        S_CWT: if (sf_ack_i) begin
          if (idx == 2'd3) st <= S_GAP;
          else begin
            idx <= idx + 1'b1;
            st  <= S_CGO;
          end
        end
        S_GAP: st <= S_PGO;
        S_PGO: st <= S_PWT;
        S_PWT: if (sf_ack_i) st <= S_RGO;
        S_RGO: st <= S_RWT;
        S_RWT: if (sf_ack_i) begin
          if (sf_rx_i[7])               st <= S_NEXT;
          else if (tcnt >= tmo_limit_i) begin
            bad <= 1'b1;
            tmo <= 1'b1;
            st  <= S_FIN;
          end else                      st <= S_GAP;
        end
        S_NEXT: begin
          page  <= page + 1'b1;
          pages <= pages - 1'b1;
          idx   <= '0;
          st    <= (pages == ADDR_W'(1)) ? S_FIN : S_CGO;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  misalign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start_i && misal) |-> ##2 (err_o && !err_tmo_o));

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_o && !err_o && start_i) |=> busy_o);

  // R3
  result_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |-> ($past(busy_o) && !busy_o));

  // R7
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CWT && sf_ack_i && idx == 2'd3) |=> !sf_cs_o);

  // R7
  repoll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RWT && sf_ack_i && !sf_rx_i[7] && tcnt < tmo_limit_i) |=> (!sf_cs_o && busy_o));
endmodule

// File: tb/page_erase_seq_tb.sv
module page_erase_seq_tb;
  localparam int PBYTES = 264;
  localparam int SHIFT  = 9;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        start_i = 0;
  logic [23:0] ofs_i = '0, len_i = '0;
  logic [31:0] tmo_limit_i = 32'd100000;
  logic        busy_o, done_o, err_o, err_tmo_o;
  logic        sf_cs_o, sf_go_o, sf_ack_i = 0;
  logic [7:0]  sf_tx_o, sf_rx_i = 8'hFF;

  int checks = 0, errors = 0;

  page_erase_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ofs_i(ofs_i), .len_i(len_i),
    .tmo_limit_i(tmo_limit_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .err_tmo_o(err_tmo_o), .sf_cs_o(sf_cs_o), .sf_go_o(sf_go_o), .sf_tx_o(sf_tx_o),
    .sf_ack_i(sf_ack_i), .sf_rx_i(sf_rx_i)
  );

  always #5 clk = ~clk;

  // flash model
  logic [7:0] tb_bytes [0:7];
  logic [7:0] c_op [0:63];
  logic [7:0] c_a1 [0:63];
  logic [7:0] c_a2 [0:63];
  logic [7:0] c_a3 [0:63];
  int  nb = 0, lat = 0, busy_left = 0, busy_polls = 2;
  int  n_cmd = 0, n_poll = 0, n_go = 0, bad_txn = 0;
  bit  stuck = 0, prev_cs = 0;
  logic [7:0] resp = 8'hFF;

  always @(negedge clk) begin
    sf_ack_i = 0;
    if (lat > 0) begin
      lat = lat - 1;
      if (lat == 0) begin
        sf_ack_i = 1;
        sf_rx_i  = resp;
      end
    end
    if (sf_go_o) begin
      n_go = n_go + 1;
      if (lat > 0 || !sf_cs_o) bad_txn = bad_txn + 1;
      lat = 2;
      resp = 8'hFF;
      if (nb == 1 && tb_bytes[0] == 8'hD7) begin
        if (stuck || busy_left > 0) begin
          resp = 8'h7F;
          if (!stuck) busy_left = busy_left - 1;
        end else resp = 8'h80;
      end
      if (nb < 8) tb_bytes[nb] = sf_tx_o;
      nb = nb + 1;
    end
    if (prev_cs && !sf_cs_o) begin
      if (nb == 4 && (tb_bytes[0] == 8'h50 || tb_bytes[0] == 8'h81)) begin
        if (n_cmd < 64) begin
          c_op[n_cmd] = tb_bytes[0];
          c_a1[n_cmd] = tb_bytes[1];
          c_a2[n_cmd] = tb_bytes[2];
          c_a3[n_cmd] = tb_bytes[3];
        end
        n_cmd = n_cmd + 1;
        busy_left = busy_polls;
      end else if (nb == 2 && tb_bytes[0] == 8'hD7 && tb_bytes[1] == 8'h00)
        n_poll = n_poll + 1;
      else bad_txn = bad_txn + 1;
      nb = 0;
    end
    prev_cs = sf_cs_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    n_cmd = 0; n_poll = 0; n_go = 0; bad_txn = 0;
  endtask

  // drive a request; cyc = falling edges from start to pulse
  task automatic run(input int ofs, input int len, output int cyc,
                     output bit gd, output bit ge, output bit gt);
    clear_log();
    @(negedge clk);
    ofs_i = 24'(ofs); len_i = 24'(len); start_i = 1;
    @(negedge clk);
    start_i = 0;
    cyc = 1;
    chk(busy_o == 1, "R3 busy after start", int'(busy_o), 1);
    while (!done_o && !err_o && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    gd = done_o; ge = err_o; gt = err_tmo_o;
    chk(busy_o == 0, "R3 busy low at pulse", int'(busy_o), 0);
    @(negedge clk);
    chk(!done_o && !err_o, "R3 one-cycle pulse", int'(done_o | err_o), 0);
  endtask

  function automatic logic [7:0] exp_op(input int pg, input int rem);
    return ((pg % 8) == 0 && rem >= 8) ? 8'h50 : 8'h81;
  endfunction

  task automatic check_cmds(input int pg0, input int n, input string tag);
    chk(n_cmd == n, {tag, " command count"}, n_cmd, n);
    chk(n_poll == n * (busy_polls + 1), "R7 poll frames", n_poll, n * (busy_polls + 1));
    chk(bad_txn == 0, "R7 frame format", bad_txn, 0);
    for (int i = 0; i < n && i < 64; i++) begin
      int pg = pg0 + i;
      logic [23:0] a = 24'(pg << SHIFT);
      chk(c_op[i] == exp_op(pg, n - i), "R5 opcode", int'(c_op[i]), int'(exp_op(pg, n - i)));
      chk(c_a1[i] == a[23:16] && c_a2[i] == a[15:8] && c_a3[i] == 8'h00,
          "R4 address bytes", int'({c_a1[i], c_a2[i], c_a3[i]}), int'({a[23:8], 8'h00}));
    end
  endtask

  task automatic t_reset();
    chk(!busy_o && !done_o && !err_o && !sf_cs_o && !sf_go_o, "R3 reset state",
        int'({busy_o, done_o, err_o, sf_cs_o, sf_go_o}), 0);
  endtask

  task automatic t_misalign();
    int c; bit d, e, t;
    run(PBYTES * 2 + 5, PBYTES, c, d, e, t);
    chk(e && !d && !t, "R1 offset error", int'({d, e, t}), 2);
    chk(c == 2, "R1 error timing", c, 2);
    chk(n_go == 0, "R1 no spi", n_go, 0);
    run(PBYTES * 3, PBYTES + 1, c, d, e, t);
    chk(e && !d && !t, "R1 length error", int'({d, e, t}), 2);
    chk(n_go == 0, "R1 no spi len", n_go, 0);
  endtask

  task automatic t_zero();
    int c; bit d, e, t;
    run(PBYTES * 4, 0, c, d, e, t);
    chk(d && !e, "R2 zero done", int'({d, e}), 2);
    chk(c == 2, "R2 done timing", c, 2);
    chk(n_go == 0, "R2 no spi", n_go, 0);
  endtask

  task automatic t_span(input int pg0, input int n, input string tag);
    int c; bit d, e, t;
    run(pg0 * PBYTES, n * PBYTES, c, d, e, t);
    chk(d && !e, {"R9 done ", tag}, int'({d, e}), 2);
    check_cmds(pg0, n, {"R6 ", tag});
  endtask

  task automatic t_timeout();
    int c; bit d, e, t;
    stuck = 1; tmo_limit_i = 32'd40;
    run(PBYTES * 8, PBYTES * 3, c, d, e, t);
    chk(e && t && !d, "R8 timeout error", int'({d, e, t}), 3);
    chk(n_cmd == 1, "R8 no further command", n_cmd, 1);
    chk(n_poll >= 2, "R8 polled before timeout", n_poll, 2);
    stuck = 0; tmo_limit_i = 32'd100000;
  endtask

  task automatic t_slow_ok();
    busy_polls = 6;
    t_span(1, 2, "R8 no early timeout");
    busy_polls = 2;
  endtask

  task automatic t_ignore_start();
    int c = 0;
    clear_log();
    @(negedge clk);
    ofs_i = 24'(PBYTES * 16); len_i = 24'(PBYTES * 2); start_i = 1;
    @(negedge clk);
    start_i = 0;
    repeat (10) @(negedge clk);
    ofs_i = 24'(PBYTES + 3); len_i = 24'(PBYTES * 5); start_i = 1;
    @(negedge clk);
    start_i = 0;
    while (!done_o && !err_o && c < 20000) begin
      @(negedge clk);
      c++;
    end
    chk(done_o && !err_o, "R3 start ignored while busy", int'({done_o, err_o}), 2);
    @(negedge clk);
    check_cmds(16, 2, "R3 ignored start");
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_misalign();
    t_zero();
    t_span(3, 1, "single");
    t_span(0, 16, "two blocks");
    t_span(8, 8, "one block");
    t_span(0, 7, "short of block");
    t_span(4, 9, "unaligned start");
    t_span(40, 2, "high page");
    t_timeout();
    t_slow_ok();
    t_ignore_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule